// File: doc/BRIEF.md
# SIMD Predication Mask Controller

This block generates the lane enables for one SIMD processor whose lanes all follow a single instruction sequencer. When a conditional is evaluated separately in each lane, the lanes can disagree. The sequencer then runs the taken path and the not-taken path one after the other. The controller keeps a lane's datapath enabled only while the path that lane chose is running.

The sequencer reports three kinds of events: opening a conditional, switching to its alternative path, and closing it. Each opening event comes with a per-lane condition vector. The controller keeps a stack of saved masks, so conditionals may be nested. For every open level it stores the parent mask together with the condition that was captured when the level opened. The block drives the current lane-enable mask. It also raises a flag when that mask is empty, so the sequencer can skip the path. A sticky error flag records an attempt to open a level when the stack is already full.

Top module: `pred_mask_ctrl`

## Requirements
- R1: During and after reset, lane_en_o is all ones, path_empty_o is 0, overflow_o is 0 and no level is open.
- R2: An if_i event with a free stack slot saves the current mask and the condition, opens one level, and sets the mask to the current mask AND cond_i from the next cycle on.
- R3: An else_i event with at least one open level sets the mask to the saved parent mask AND NOT the condition captured at the matching if. The cond_i value presented with the else is ignored.
- R4: An endif_i event with at least one open level restores the saved parent mask and closes that level.
- R5: Up to DEPTH levels (default 8) may be open at once, and they are closed in last-in first-out order.
- R6: path_empty_o is 1 exactly when lane_en_o is all zeros, in the same cycle.
- R7: An if_i event while DEPTH levels are open leaves the mask and the stack unchanged and sets overflow_o. overflow_o then stays at 1 until reset.
- R8: An else_i or endif_i event with no open level has no effect on the mask or the stack.
- R9: When several events arrive in the same cycle, only one is acted on: if_i wins over else_i, and else_i wins over endif_i.
- R10: In a cycle with no event, the mask keeps its value whatever cond_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| if_i | input | 1 | Opens a conditional level |
| else_i | input | 1 | Switches to the alternative path of the innermost level |
| endif_i | input | 1 | Closes the innermost level |
| cond_i | input | LANES | Per-lane condition, sampled with if_i |
| lane_en_o | output | LANES | Current lane-enable mask |
| path_empty_o | output | 1 | Current mask has no active lane |
| overflow_o | output | 1 | Sticky: an open was attempted on a full stack |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Stale cond_i at else.** The bench presents a misleading cond_i with else events. A design that used that stale vector, instead of the captured condition, would enable the wrong lanes on the alternative path.
- **Overflow and stack boundary.** The bench fills the stack to its full depth, pushes once more, and then unwinds every level. This catches a push that corrupts the top entry, an overflow flag that is not sticky, and a pop that restores the wrong level.
- **Empty stack.** The bench issues else and endif with no level open. A design that underflowed its pointer would restore garbage.
- **Simultaneous events and empty paths.** The bench drives several events in one cycle to expose the wrong priority. It also opens paths whose mask is all zeros, which catches an empty flag that lags by a cycle.

// File: rtl/pred_pkg.sv
package pred_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_FLIP = 2'd2,
    OP_POP  = 2'd3
  } stack_op_e;
endpackage

// File: rtl/pred_op_decode.sv
module pred_op_decode
  import pred_pkg::*;
(
  input  logic      if_i,
  input  logic      else_i,
  input  logic      endif_i,
  input  logic      full_i,
  input  logic      empty_i,
  output stack_op_e op_o,
  output logic      ovf_hit_o
);
  // Priority: open > alternative > close
  always_comb begin
    op_o      = OP_HOLD;
    ovf_hit_o = 1'b0;
    if (if_i) begin
      if (full_i) ovf_hit_o = 1'b1;
      else        op_o      = OP_PUSH;
    end else if (else_i) begin
      if (!empty_i) op_o = OP_FLIP;
    end else if (endif_i) begin
      if (!empty_i) op_o = OP_POP;
    end
  end
endmodule

// File: rtl/pred_mask_stack.sv
module pred_mask_stack
  import pred_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DEPTH = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  stack_op_e                     op_i,
  input  logic [LANES-1:0]              push_parent_i,
  input  logic [LANES-1:0]              push_cond_i,
  output logic [LANES-1:0]              top_parent_o,
  output logic [LANES-1:0]              top_cond_o,
  output logic [$clog2(DEPTH+1)-1:0]    depth_o,
  output logic                          full_o,
  output logic                          empty_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0]    depth_q, depth_d;
  logic [IW-1:0]    top_idx, wr_idx;
  logic [LANES-1:0] parent_q [DEPTH];
  logic [LANES-1:0] cond_q   [DEPTH];

  assign wr_idx  = IW'(depth_q);
  assign top_idx = IW'(depth_q - PW'(1));
  assign full_o  = (depth_q == DEPTH_P);
  assign empty_o = (depth_q == '0);
  assign depth_o = depth_q;

  always_comb begin
    depth_d = depth_q;
    case (op_i)
      OP_PUSH: depth_d = depth_q + PW'(1);
      OP_POP:  depth_d = depth_q - PW'(1);
      default: depth_d = depth_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else         depth_q <= depth_d;
  end

  // Entry storage: data only, no reset; validity comes from depth_q
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wr_en;
    assign wr_en = (op_i == OP_PUSH) && (wr_idx == IW'(g));
    always_ff @(posedge clk_i) begin
      if (wr_en) begin
        parent_q[g] <= push_parent_i;
        cond_q[g]   <= push_cond_i;
      end
    end
  end

  assign top_parent_o = parent_q[top_idx];
  assign top_cond_o   = cond_q[top_idx];
endmodule

// File: rtl/pred_mask_next.sv
module pred_mask_next
  import pred_pkg::*;
#(
  parameter int LANES = 16
) (
  input  stack_op_e         op_i,
  input  logic [LANES-1:0]  cur_mask_i,
  input  logic [LANES-1:0]  cond_i,
  input  logic [LANES-1:0]  top_parent_i,
  input  logic [LANES-1:0]  top_cond_i,
  output logic [LANES-1:0]  next_mask_o
);
  always_comb begin
    case (op_i)
      OP_PUSH: next_mask_o = cur_mask_i & cond_i;
      OP_FLIP: next_mask_o = top_parent_i & ~top_cond_i;
      OP_POP:  next_mask_o = top_parent_i;
      default: next_mask_o = cur_mask_i;
    endcase
  end
endmodule

// File: rtl/pred_mask_ctrl.sv
module pred_mask_ctrl
  import pred_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             if_i,
  input  logic             else_i,
  input  logic             endif_i,
  input  logic [LANES-1:0] cond_i,
  output logic [LANES-1:0] lane_en_o,
  output logic             path_empty_o,
  output logic             overflow_o
);
  localparam int PW = $clog2(DEPTH + 1);

  stack_op_e        op;
  logic             ovf_hit;
  logic             stk_full, stk_empty;
  logic [PW-1:0]    stk_depth;
  logic [LANES-1:0] top_parent, top_cond;
  logic [LANES-1:0] mask_q, mask_d;
  logic             ovf_q, ovf_d;
  logic             mask_en;

  pred_op_decode u_dec (
    .if_i      (if_i),
    .else_i    (else_i),
    .endif_i   (endif_i),
    .full_i    (stk_full),
    .empty_i   (stk_empty),
    .op_o      (op),
    .ovf_hit_o (ovf_hit)
  );

  pred_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (op),
    .push_parent_i (mask_q),
    .push_cond_i   (cond_i),
    .top_parent_o  (top_parent),
    .top_cond_o    (top_cond),
    .depth_o       (stk_depth),
    .full_o        (stk_full),
    .empty_o       (stk_empty)
  );

  pred_mask_next #(.LANES(LANES)) u_next (
    .op_i         (op),
    .cur_mask_i   (mask_q),
    .cond_i       (cond_i),
    .top_parent_i (top_parent),
    .top_cond_i   (top_cond),
    .next_mask_o  (mask_d)
  );

  assign mask_en = (op != OP_HOLD);
  assign ovf_d   = ovf_q | ovf_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (ovf_hit) ovf_q  <= ovf_d;
    end
  end

  assign lane_en_o    = mask_q;
  assign path_empty_o = ~|mask_q;
  assign overflow_o   = ovf_q;
endmodule

// File: rtl/pred_mask_ctrl_chk.sv
module pred_mask_ctrl_chk #(
  parameter int LANES = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       if_i,
  input logic                       else_i,
  input logic                       endif_i,
  input logic [LANES-1:0]           lane_en_o,
  input logic                       overflow_o,
  input logic [$clog2(DEPTH+1)-1:0] stk_depth
);
  localparam int PW = $clog2(DEPTH + 1);

  // R2: opening a level never enables a lane that was off
  a_r2_if_narrows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_i && stk_depth < PW'(DEPTH)) |=> ((lane_en_o & ~$past(lane_en_o)) == '0));

  // R5: level count never exceeds the stack depth
  a_r5_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_depth <= PW'(DEPTH));

  // R7: open on a full stack keeps the mask and raises the error
  a_r7_full_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_i && stk_depth == PW'(DEPTH)) |=> (overflow_o && $stable(lane_en_o) && $stable(stk_depth)));

  // R7: the error flag is sticky
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R8: close or alternative with no open level changes nothing
  a_r8_empty_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!if_i && (else_i || endif_i) && stk_depth == '0) |=> ($stable(lane_en_o) && stk_depth == '0));

  // R10: no event keeps the mask
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!if_i && !else_i && !endif_i) |=> $stable(lane_en_o));
endmodule

bind pred_mask_ctrl pred_mask_ctrl_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .if_i       (if_i),
  .else_i     (else_i),
  .endif_i    (endif_i),
  .lane_en_o  (lane_en_o),
  .overflow_o (overflow_o),
  .stk_depth  (stk_depth)
);

// File: tb/test_pred_mask_ctrl.sv
`timescale 1ns/1ps
module test_pred_mask_ctrl;
  localparam int LANES = 16;
  localparam int DEPTH = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             if_i, else_i, endif_i;
  logic [LANES-1:0] cond_i;
  logic [LANES-1:0] lane_en_o;
  logic             path_empty_o, overflow_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk_i = ~clk_i;

  pred_mask_ctrl #(.LANES(LANES), .DEPTH(DEPTH)) i_pred_mask_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .if_i(if_i), .else_i(else_i), .endif_i(endif_i),
    .cond_i(cond_i), .lane_en_o(lane_en_o), .path_empty_o(path_empty_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of events, sample after the edge
  task automatic step(input logic i, input logic e, input logic n, input logic [LANES-1:0] c,
                      input logic [LANES-1:0] exp_m, input logic exp_o, input string req);
    @(negedge clk_i);
    if_i = i; else_i = e; endif_i = n; cond_i = c;
    @(negedge clk_i);
    if_i = 0; else_i = 0; endif_i = 0;
    chk({req, " mask"}, 32'(lane_en_o), 32'(exp_m));
    chk({req, " empty(R6)"}, 32'(path_empty_o), 32'(exp_m == '0));
    chk({req, " overflow"}, 32'(overflow_o), 32'(exp_o));
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rst_ni = 0; if_i = 0; else_i = 0; endif_i = 0; cond_i = '0;
    @(negedge clk_i);
    chk("R1 mask in reset", 32'(lane_en_o), 32'hFFFF);
    chk("R1 empty in reset", 32'(path_empty_o), 0);
    chk("R1 overflow in reset", 32'(overflow_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 mask after reset", 32'(lane_en_o), 32'hFFFF);
    // R1: no level open, so a close is a no-op
    step(0, 0, 1, 16'h0000, 16'hFFFF, 0, "R1 no open level");
  endtask

  task automatic t_basic();
    step(1, 0, 0, 16'h00FF, 16'h00FF, 0, "R2 if");
    step(0, 1, 0, 16'hAAAA, 16'hFF00, 0, "R3 else ignores cond");
    step(0, 0, 1, 16'h1234, 16'hFFFF, 0, "R4 endif");
  endtask

  task automatic t_nested();
    step(1, 0, 0, 16'h0F0F, 16'h0F0F, 0, "R5 outer if");
    step(1, 0, 0, 16'h00FF, 16'h000F, 0, "R5 inner if");
    step(0, 1, 0, 16'hFFFF, 16'h0F00, 0, "R5 inner else");
    step(0, 0, 1, 16'h0000, 16'h0F0F, 0, "R5 inner endif");
    step(0, 1, 0, 16'h0000, 16'hF0F0, 0, "R5 outer else");
    step(0, 0, 1, 16'h0000, 16'hFFFF, 0, "R5 outer endif");
  endtask

  task automatic t_empty_path();
    step(1, 0, 0, 16'h0000, 16'h0000, 0, "R6 all lanes off");
    step(0, 1, 0, 16'h0000, 16'hFFFF, 0, "R6 else all on");
    step(0, 0, 1, 16'h0000, 16'hFFFF, 0, "R6 endif");
  endtask

  task automatic t_priority();
    step(1, 1, 1, 16'h3333, 16'h3333, 0, "R9 if wins");
    step(0, 1, 1, 16'h0000, 16'hCCCC, 0, "R9 else wins");
    step(0, 0, 1, 16'h0000, 16'hFFFF, 0, "R9 endif alone");
  endtask

  task automatic t_idle();
    step(1, 0, 0, 16'h5A5A, 16'h5A5A, 0, "R10 setup");
    for (int k = 0; k < 3; k++) step(0, 0, 0, 16'(k * 16'h1111), 16'h5A5A, 0, "R10 hold");
    step(0, 0, 1, 16'h0000, 16'hFFFF, 0, "R10 endif");
  endtask

  task automatic t_underflow();
    step(0, 1, 0, 16'h00FF, 16'hFFFF, 0, "R8 else no level");
    step(0, 0, 1, 16'h00FF, 16'hFFFF, 0, "R8 endif no level");
  endtask

  task automatic t_overflow();
    for (int k = 0; k < DEPTH; k++)
      step(1, 0, 0, ~(16'h1 << k), 16'hFFFF << (k + 1), 0, "R5 fill");
    step(1, 0, 0, 16'h0000, 16'hFF00, 1, "R7 push on full");
    for (int j = 1; j <= DEPTH; j++)
      step(0, 0, 1, 16'h0000, 16'hFFFF << (DEPTH - j), 1, "R7 unwind sticky");
    step(0, 0, 1, 16'h0000, 16'hFFFF, 1, "R8 extra endif");
  endtask

  initial begin
    rst_ni = 0; if_i = 0; else_i = 0; endif_i = 0; cond_i = '0;
    t_reset();
    t_basic();
    t_nested();
    t_empty_path();
    t_priority();
    t_idle();
    t_underflow();
    t_overflow();
    t_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule